// File: doc/BRIEF.md
# Scaled Fractional Baud Rate Generator

This block derives the timing pulses for a serial transmitter and receiver from the peripheral clock. Software-visible logic elsewhere presents a 12-bit unsigned divisor, a 4-bit signed power-of-two exponent, a double-speed flag and a synchronous-master flag, together with a one-cycle write strobe. The block captures these values on the strobe and restarts its timing from that point.

In the asynchronous modes the block produces an oversampling pulse and a bit pulse. A non-negative exponent multiplies the divisor period by a power of two. A negative exponent instead treats the low divisor bits as a binary fraction of the period. A small accumulator adds that fraction once per period, and each carry out of it stretches one period by a single cycle, so the average spacing follows the fractional value. The bit pulse marks every sixteenth oversampling pulse, or every eighth one when double speed is selected. In synchronous master mode the block toggles a bit clock output on every oversampling pulse and ignores the exponent.

Top module: `baud_gen`

## Requirements
- R1: While rst_n is low, os_tick, bit_tick and xck_out are low. The configuration resets to divisor 0, exponent 0 and asynchronous normal speed, so from the first cycle after reset os_tick is high in every cycle.
- R2: With cfg_sync=0 and an exponent s from 0 to 7 (cfg_scale[3]=0), consecutive os_tick pulses are exactly (cfg_div+1)·2^s cycles apart.
- R3: With cfg_sync=0 and a negative exponent −k (two's complement in cfg_scale), the base period is (cfg_div>>k)+1 cycles. Let f be the low k bits of cfg_div. After each period, a k-bit accumulator that was cleared at the write adds f, and every carry out of it makes the next period one cycle longer. The n-th pulse after a write therefore comes n·((cfg_div>>k)+1) + floor((n−1)·f/2^k) cycles after the write.
- R4: With cfg_dbl=1 in an asynchronous mode, the os_tick spacing is the same as with cfg_dbl=0, and bit_tick is high together with every 8th os_tick after a write and with no other.
- R5: With cfg_dbl=0 in an asynchronous mode, bit_tick is high together with every 16th os_tick after a write and at no other time.
- R6: With cfg_sync=1, os_tick pulses are cfg_div+1 cycles apart whatever cfg_scale and cfg_dbl hold. xck_out is 0 after a write and toggles in the cycle of every os_tick, so its period is 2·(cfg_div+1). bit_tick is high with each os_tick that drives xck_out from 0 to 1.
- R7: With cfg_sync=0, xck_out stays 0.
- R8: The values captured on a write take effect at once. In the cycle after the write edge os_tick is 0, even if a pulse was due in that cycle. The first pulse comes exactly one base period (R2, R3 or R6) after the write edge.
- R9: The code cfg_scale=4'b1000 (−8) is outside the range and behaves exactly like −7 (4'b1001).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | One-cycle strobe that captures the configuration and restarts timing |
| cfg_div | input | 12 | Unsigned divisor |
| cfg_scale | input | 4 | Signed power-of-two exponent, two's complement |
| cfg_dbl | input | 1 | 1 selects 8 oversamples per bit instead of 16 |
| cfg_sync | input | 1 | 1 selects synchronous master mode with a bit clock output |
| os_tick | output | 1 | One-cycle oversampling pulse |
| bit_tick | output | 1 | One-cycle pulse per bit, coincident with an os_tick |
| xck_out | output | 1 | Master bit clock in synchronous mode, else 0 |

## Verification
A configuration write can fall on the same edge at which the running counter expires and would raise os_tick. The bench provokes this by waiting for a pulse with a four-cycle period, then timing the next write so that its edge lands on the fourth cycle after that pulse. The write must win: os_tick must be low in the following cycle, and the first pulse under the new values must come exactly one new period later. The coincidence of os_tick and bit_tick is judged at every pulse against a count of pulses held by the bench.

// File: rtl/baud_pkg.sv
// Package: shared widths, the captured configuration type and period math.
// Assumes the divisor is at least as wide as the largest exponent magnitude.
package baud_pkg;
    localparam int DIV_W   = 12;
    localparam int SCALE_W = 4;
    localparam int MAG_W   = SCALE_W - 1;
    localparam int MAG_MAX = (1 << MAG_W) - 1;
    localparam int LEN_W   = DIV_W + MAG_MAX + 1;
    localparam int OS_NORM = 16;
    localparam int OS_DBL  = 8;
    localparam int OS_CW   = $clog2(OS_NORM);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             neg;
        logic [MAG_W-1:0] mag;
        logic             dbl;
        logic             sync;
    } cfg_t;

    // Turn the raw fields into sign and magnitude, clamping the most negative code.
    function automatic cfg_t decode_cfg(input logic [DIV_W-1:0] div,
                                        input logic [SCALE_W-1:0] scale,
                                        input logic dbl,
                                        input logic sync);
        cfg_t c;
        logic [SCALE_W-1:0] m;
        c.div  = div;
        c.dbl  = dbl;
        c.sync = sync;
        c.neg  = scale[SCALE_W-1];
        m      = -scale;
        if (!c.neg)
            c.mag = scale[MAG_W-1:0];
        else if (scale[MAG_W-1:0] == '0)
            c.mag = MAG_W'(MAG_MAX);
        else
            c.mag = m[MAG_W-1:0];
        return c;
    endfunction

    // Base period length in cycles, before any fractional stretch.
    function automatic logic [LEN_W-1:0] base_len(input cfg_t c);
        logic [LEN_W-1:0] d1;
        d1 = LEN_W'(c.div) + LEN_W'(1);
        if (c.sync)
            return d1;
        else if (c.neg)
            return LEN_W'(c.div >> c.mag) + LEN_W'(1);
        else
            return d1 << c.mag;
    endfunction
endpackage

// File: rtl/baud_frac.sv
// Fractional accumulator: adds the low divisor bits once per period and
// reports a carry that stretches the next period by one cycle.
// Assumes cfg only changes in a cycle where clear is high.
module baud_frac
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    input  cfg_t cfg,
    output logic carry
);
    logic [MAG_MAX-1:0] acc;
    logic [MAG_MAX-1:0] mask;
    logic [MAG_MAX-1:0] frac;
    logic [MAG_MAX:0]   sum;

    // Fraction bits selected by the exponent magnitude and their running sum.
    always_comb begin
        mask  = ~({MAG_MAX{1'b1}} << cfg.mag);
        frac  = cfg.div[MAG_MAX-1:0] & mask;
        sum   = {1'b0, acc} + {1'b0, frac};
        carry = cfg.neg && !cfg.sync && sum[cfg.mag];
    end

    // Accumulator register: cleared on a write, advanced at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            acc <= '0;
        else if (advance)
            acc <= sum[MAG_MAX-1:0] & mask;
    end

    // R3: the accumulator never holds bits above the active fraction width.
    a_r3_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
        (acc & ~mask) == '0);
endmodule

// File: rtl/baud_count.sv
// Period counter: loads the first length on a write, reloads at expiry.
// Assumes every length presented is at least one.
module baud_count
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic [LEN_W-1:0] reload_len,
    output logic             expire
);
    logic [LEN_W-1:0] cnt;

    // Expiry at zero, suppressed by a write in the same cycle.
    always_comb expire = (cnt == '0) && !load;

    // Down counter holding the remaining cycles of the current period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_len - LEN_W'(1);
        else if (cnt == '0)
            cnt <= reload_len - LEN_W'(1);
        else
            cnt <= cnt - LEN_W'(1);
    end

    // R8: a write is never itself an expiry.
    a_r8_load_blocks_expire: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !expire);
endmodule

// File: rtl/baud_tickdiv.sv
// Output stage: registers the oversampling pulse, divides it into bit
// pulses and toggles the master bit clock in synchronous mode.
// Assumes expire is a single-cycle strobe from the period counter.
module baud_tickdiv
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic expire,
    input  cfg_t cfg,
    output logic os_tick,
    output logic bit_tick,
    output logic xck_out
);
    logic [OS_CW-1:0] os_cnt;
    logic [OS_CW-1:0] os_last;

    // Last oversample index of a bit for the selected speed.
    always_comb os_last = cfg.dbl ? OS_CW'(OS_DBL - 1) : OS_CW'(OS_NORM - 1);

    // Pulse, bit divider and bit clock registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
            xck_out  <= 1'b0;
            os_cnt   <= '0;
        end else begin
            os_tick  <= expire;
            bit_tick <= 1'b0;
            if (expire) begin
                if (cfg.sync) begin
                    xck_out  <= ~xck_out;
                    bit_tick <= ~xck_out;
                end else begin
                    bit_tick <= (os_cnt == os_last);
                    os_cnt   <= (os_cnt == os_last) ? '0 : os_cnt + OS_CW'(1);
                end
            end
        end
    end

    // R5: a bit pulse always coincides with an oversampling pulse.
    a_r5_bit_with_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
    // R7: no bit clock activity in the asynchronous modes.
    a_r7_xck_idle_async: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.sync |-> !xck_out);
    // R6: the bit clock only moves with an oversampling pulse, apart from a write.
    a_r6_xck_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ((xck_out != $past(xck_out)) && !$past(clear)) |-> os_tick);
endmodule

// File: rtl/baud_gen.sv
// Top: captures the configuration on a write strobe and wires the period
// counter, fractional accumulator and output stage together.
// Assumes cfg_we is a single-cycle strobe synchronous to clk.
module baud_gen
    import baud_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [SCALE_W-1:0] cfg_scale,
    input  logic               cfg_dbl,
    input  logic               cfg_sync,
    output logic               os_tick,
    output logic               bit_tick,
    output logic               xck_out
);
    cfg_t             cfg_new;
    cfg_t             cfg_q;
    logic             expire;
    logic             carry;
    logic [LEN_W-1:0] load_len;
    logic [LEN_W-1:0] reload_len;

    // Decoded incoming values and the period lengths for load and reload.
    always_comb begin
        cfg_new    = decode_cfg(cfg_div, cfg_scale, cfg_dbl, cfg_sync);
        load_len   = base_len(cfg_new);
        reload_len = base_len(cfg_q) + LEN_W'(carry);
    end

    // Configuration register, written by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= decode_cfg('0, '0, 1'b0, 1'b0);
        else if (cfg_we)
            cfg_q <= cfg_new;
    end

    baud_count u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_we),
        .load_len   (load_len),
        .reload_len (reload_len),
        .expire     (expire)
    );

    baud_frac u_frac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cfg_we),
        .advance (expire),
        .cfg     (cfg_q),
        .carry   (carry)
    );

    baud_tickdiv u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cfg_we),
        .expire   (expire),
        .cfg      (cfg_q),
        .os_tick  (os_tick),
        .bit_tick (bit_tick),
        .xck_out  (xck_out)
    );

    // R8: the cycle after a write never carries a pulse.
    a_r8_write_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !os_tick);
    // R1: reset holds every output low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!os_tick && !bit_tick && !xck_out));
endmodule

// File: tb/baud_gen_tb.sv
module baud_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_div = '0;
    logic [3:0]  cfg_scale = '0;
    logic        cfg_dbl = 1'b0;
    logic        cfg_sync = 1'b0;
    logic        os_tick, bit_tick, xck_out;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    int last_t;

    baud_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
        .cfg_scale(cfg_scale), .cfg_dbl(cfg_dbl), .cfg_sync(cfg_sync),
        .os_tick(os_tick), .bit_tick(bit_tick), .xck_out(xck_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Exponent magnitude, with -8 treated as -7 (R9).
    function automatic int mag_of(input logic [3:0] s);
        if (!s[3]) return int'(s);
        if (s == 4'b1000) return 7;
        return 16 - int'(s);
    endfunction

    function automatic int exp_base(input int div, input logic [3:0] s, input bit sync);
        if (sync) return div + 1;
        if (s[3]) return (div >> mag_of(s)) + 1;
        return (div + 1) << mag_of(s);
    endfunction

    task automatic do_write(input int div, input logic [3:0] s, input bit dbl, input bit sync);
        @(negedge clk);
        cfg_div = 12'(div); cfg_scale = s; cfg_dbl = dbl; cfg_sync = sync;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(os_tick == 1'b0, "R8", "no pulse right after write", int'(os_tick), 0);
    endtask

    task automatic measure(input int div, input logic [3:0] s, input bit dbl,
                           input bit sync, input int n);
        int base, k, f, ratio, t, i, first, last, bad_bit, bad_xck, exp_last, limit;
        string rq_len, rq_bit, rq_x;
        bit neg;
        base  = exp_base(div, s, sync);
        k     = mag_of(s);
        neg   = s[3] && !sync;
        f     = neg ? (div & ((1 << k) - 1)) : 0;
        ratio = dbl ? 8 : 16;
        exp_last = n * base + (neg ? (((n - 1) * f) >> k) : 0);
        rq_len = sync ? "R6" : (dbl ? "R4" : (neg ? "R3" : "R2"));
        rq_bit = sync ? "R6" : (dbl ? "R4" : "R5");
        rq_x   = sync ? "R6" : "R7";
        do_write(div, s, dbl, sync);
        t = 0; i = 0; first = -1; last = -1; bad_bit = 0; bad_xck = 0;
        limit = 2 * exp_last + 100;
        while (i < n && t < limit) begin
            @(negedge clk);
            t++;
            if (os_tick) begin
                i++;
                if (i == 1) first = t;
                last = t;
                if (bit_tick != (sync ? (i % 2 == 1) : (i % ratio == 0))) bad_bit++;
            end else if (bit_tick) begin
                bad_bit++;
            end
            if (xck_out != (sync ? (i % 2 == 1) : 1'b0)) bad_xck++;
        end
        chk(first == base, "R8", "first pulse delay", first, base);
        chk(last == exp_last, rq_len, "time of last pulse", last, exp_last);
        chk(bad_bit == 0, rq_bit, "bit pulse mismatches", bad_bit, 0);
        chk(bad_xck == 0, rq_x, "bit clock mismatches", bad_xck, 0);
        last_t = last;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int ref_t;
        void'($urandom(32'h5eed_1234));
        // R1: outputs quiet in reset, then default of one pulse per cycle.
        repeat (4) @(negedge clk);
        chk(!os_tick && !bit_tick && !xck_out, "R1", "outputs in reset",
            int'({os_tick, bit_tick, xck_out}), 0);
        rst_n = 1'b1;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(os_tick == 1'b1, "R1", "default pulse every cycle", int'(os_tick), 1);
        end
        // Directed corner cases.
        measure(0, 4'd0, 1'b0, 1'b0, 64);
        measure(5, 4'd3, 1'b0, 1'b0, 32);
        measure(5, 4'd3, 1'b1, 1'b0, 32);
        measure(4095, 4'b1001, 1'b0, 1'b0, 256);
        ref_t = last_t;
        measure(4095, 4'b1000, 1'b0, 1'b0, 256);
        chk(last_t == ref_t, "R9", "code -8 matches -7", last_t, ref_t);
        measure(21, 4'b1110, 1'b1, 1'b0, 64);
        measure(9, 4'b1101, 1'b1, 1'b1, 20);
        // Write landing on the edge of a due pulse (R8).
        measure(3, 4'd0, 1'b0, 1'b0, 4);
        repeat (2) @(negedge clk);
        measure(7, 4'd0, 1'b0, 1'b0, 8);
        // Constrained random configurations.
        for (int r = 0; r < 12; r++) begin
            int d, sc;
            d  = int'($urandom_range(0, 40));
            sc = int'($urandom_range(0, 9)) - 7;
            measure(d, 4'(sc), 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0), 32);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule